// File: doc/BRIEF.md
# Dual-Channel Serial Pattern Generator

The block drives two independent serial outputs. Each channel sends a programmed bit pattern, of up to 64 bits, on a data pin together with a clock pin that the block generates. The clock rate comes from a per-channel divider. The pattern repeats a programmed number of times. The clock polarity and the resting levels of both pins can be set per channel. When a channel finishes, it sets a sticky done flag, and that flag can raise an interrupt line.

Software programs the block through a flat word-addressed register port with a write strobe and a combinational read port. Two fields encode their value minus one: the length and the repeat count. The divider register also encodes its value minus one. Both enable bits share one control word. Setting both enables in a single write starts the two channels on the same cycle. Clearing a channel's enable stops its output at once, and the done flag for that channel does not set.

Top module: `pg_dual`

## Requirements
- R1: Register word addresses are: 0 control, 1 and 2 divider of channel 0 and 1, 3/4 pattern bits 31:0 / 63:32 of channel 0, 5/6 the same for channel 1, 7 and 8 shape of channel 0 and 1 (length-minus-one in bits 9:0, repeats-minus-one in bits 21:16), 9 done flags, 10 interrupt enables (bit c = channel c in both). Control bits: 1:0 enables, 3:2 polarity, 5:4 idle clock level, 7:6 idle data level. All registers reset to zero and read back what was written, and unused addresses read zero.
- R2: With divider value D, each half of a bit period lasts D+1 cycles. The first bit appears on the cycle after the edge that captured the enabling write.
- R3: Bits are sent least-significant first. After bit index `len` the index wraps to 0. A run sends (len+1)×(reps+1) bits.
- R4: A length value above 63 behaves as 63, so a run never reads past the 64-bit pattern.
- R5: With polarity 0 the clock is low in the first half of each bit and high in the second half, so data changes only on falling edges. Polarity 1 inverts the clock.
- R6: While a channel is disabled, and after it has finished, its clock and data pins sit at the channel's idle levels. The enable bit stays set after completion.
- R7: The done flag of a channel sets in the cycle its pins return to idle after the last bit. The interrupt line of a channel is the done flag ANDed with its enable bit.
- R8: Writing 1 to a done-flag bit clears it. Writing 0 leaves it unchanged, and a flag never clears by any other means.
- R9: One control write that sets both enables starts both channels on the same cycle. Each channel then follows its own timing from that common start.
- R10: Clearing an enable during a run puts that channel's pins at idle on the next cycle, and its done flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address (write and read) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pcl_o | output | 2 | Generated clock, one bit per channel |
| pda_o | output | 2 | Serial data, one bit per channel |
| irq_o | output | 2 | Done interrupt, one bit per channel |

## Verification
A write is captured on a clock edge. Control and flag effects show from that edge on, and a run's first bit appears one edge later. The bench starts its cycle count t at that second edge and samples at every falling edge. In each sampled cycle it compares both channels' pins with a model that computes, from t, the divider, the length and the repeat count, the expected phase and bit index. The same model predicts the done flag for t ≥ 2(D+1)(len+1)(reps+1). After an abort, the pins are checked at the first falling edge after the write edge. The done flag is then watched for a long window afterwards.

// File: rtl/pg_pkg.sv
package pg_pkg;
    localparam int NCH        = 2;
    localparam int DIV_W      = 32;
    localparam int PAT_W      = 64;
    localparam int LEN_W      = 10;
    localparam int REP_W      = 6;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 32;
    localparam int CTRL_W     = 4 * NCH;
    localparam int REP_LSB    = 16;
    localparam int WORDS_PAT  = PAT_W / DATA_W;

    localparam int A_CTRL     = 0;
    localparam int A_DIV      = 1;
    localparam int A_PAT      = A_DIV + NCH;
    localparam int A_SHAPE    = A_PAT + WORDS_PAT * NCH;
    localparam int A_INT_ST   = A_SHAPE + NCH;
    localparam int A_INT_EN   = A_INT_ST + 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PAT_W-1:0] pat;
        logic [LEN_W-1:0] len;
        logic [REP_W-1:0] reps;
    } ch_cfg_t;
endpackage

// File: rtl/pg_regfile.sv
module pg_regfile
    import pg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic [NCH-1:0]              done,
    output logic [CTRL_W-1:0]           ctrl,
    output ch_cfg_t [NCH-1:0]           cfg,
    output logic [NCH-1:0]              int_st,
    output logic [NCH-1:0]              int_en
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        ch_cfg_t [NCH-1:0] cfg;
        logic [NCH-1:0]    int_st;
        logic [NCH-1:0]    int_en;
    } rf_t;

    rf_t rf_d, rf_q;
    logic [NCH-1:0] clr;

    always_comb begin
        rf_d = rf_q;
        clr  = '0;
        if (reg_we) begin
            if (reg_addr == ADDR_W'(A_CTRL))   rf_d.ctrl   = reg_wdata[CTRL_W-1:0];
            if (reg_addr == ADDR_W'(A_INT_EN)) rf_d.int_en = reg_wdata[NCH-1:0];
            if (reg_addr == ADDR_W'(A_INT_ST)) clr         = reg_wdata[NCH-1:0];
            for (int c = 0; c < NCH; c++) begin
                if (reg_addr == ADDR_W'(A_DIV + c)) rf_d.cfg[c].div = reg_wdata;
                for (int w = 0; w < WORDS_PAT; w++)
                    if (reg_addr == ADDR_W'(A_PAT + WORDS_PAT * c + w))
                        rf_d.cfg[c].pat[w*DATA_W +: DATA_W] = reg_wdata;
                if (reg_addr == ADDR_W'(A_SHAPE + c)) begin
                    rf_d.cfg[c].len  = reg_wdata[LEN_W-1:0];
                    rf_d.cfg[c].reps = reg_wdata[REP_LSB +: REP_W];
                end
            end
        end
        rf_d.int_st = (rf_q.int_st & ~clr) | done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL))   reg_rdata[CTRL_W-1:0] = rf_q.ctrl;
        if (reg_addr == ADDR_W'(A_INT_ST)) reg_rdata[NCH-1:0]    = rf_q.int_st;
        if (reg_addr == ADDR_W'(A_INT_EN)) reg_rdata[NCH-1:0]    = rf_q.int_en;
        for (int c = 0; c < NCH; c++) begin
            if (reg_addr == ADDR_W'(A_DIV + c)) reg_rdata = rf_q.cfg[c].div;
            for (int w = 0; w < WORDS_PAT; w++)
                if (reg_addr == ADDR_W'(A_PAT + WORDS_PAT * c + w))
                    reg_rdata = rf_q.cfg[c].pat[w*DATA_W +: DATA_W];
            if (reg_addr == ADDR_W'(A_SHAPE + c)) begin
                reg_rdata[LEN_W-1:0]          = rf_q.cfg[c].len;
                reg_rdata[REP_LSB +: REP_W]   = rf_q.cfg[c].reps;
            end
        end
    end

    assign ctrl   = rf_q.ctrl;
    assign cfg    = rf_q.cfg;
    assign int_st = rf_q.int_st;
    assign int_en = rf_q.int_en;
endmodule

// File: rtl/pg_channel.sv
module pg_channel
    import pg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    pol,
    input  logic    idle_clk,
    input  logic    idle_dat,
    input  ch_cfg_t cfg,
    output logic    pcl,
    output logic    pda,
    output logic    busy,
    output logic    done
);
    localparam int IDX_W   = $clog2(PAT_W);
    localparam int MAX_IDX = PAT_W - 1;

    typedef struct packed {
        logic             active;
        logic             finished;
        logic             phase;
        logic [DIV_W-1:0] div_cnt;
        logic [IDX_W-1:0] idx;
        logic [REP_W-1:0] rep;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic [IDX_W-1:0] last_idx;
    logic             half_end;

    always_comb begin
        last_idx = (cfg.len > LEN_W'(MAX_IDX)) ? IDX_W'(MAX_IDX) : cfg.len[IDX_W-1:0];
        half_end = (st_q.div_cnt >= cfg.div);
        st_d     = st_q;
        done     = 1'b0;
        if (!en) begin
            st_d = '0;
        end else if (!st_q.active) begin
            if (!st_q.finished) begin
                st_d        = '0;
                st_d.active = 1'b1;
            end
        end else if (!half_end) begin
            st_d.div_cnt = st_q.div_cnt + 1'b1;
        end else begin
            st_d.div_cnt = '0;
            st_d.phase   = ~st_q.phase;
            if (st_q.phase) begin
                if (st_q.idx == last_idx) begin
                    st_d.idx = '0;
                    if (st_q.rep == cfg.reps) begin
                        st_d.active   = 1'b0;
                        st_d.finished = 1'b1;
                        done          = 1'b1;
                    end else begin
                        st_d.rep = st_q.rep + 1'b1;
                    end
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.active && en;
    assign pcl  = busy ? (st_q.phase ^ pol) : idle_clk;
    assign pda  = busy ? cfg.pat[st_q.idx]  : idle_dat;
endmodule

// File: rtl/pg_dual.sv
module pg_dual
    import pg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCH-1:0]    pcl_o,
    output logic [NCH-1:0]    pda_o,
    output logic [NCH-1:0]    irq_o
);
    logic [CTRL_W-1:0]  ctrl;
    ch_cfg_t [NCH-1:0]  cfg;
    logic [NCH-1:0]     int_st, int_en, ch_busy, ch_done;

    pg_regfile u_rf (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .done(ch_done), .ctrl, .cfg, .int_st, .int_en
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pg_channel u_ch (
            .clk, .rst_n,
            .en      (ctrl[c]),
            .pol     (ctrl[NCH + c]),
            .idle_clk(ctrl[2*NCH + c]),
            .idle_dat(ctrl[3*NCH + c]),
            .cfg     (cfg[c]),
            .pcl     (pcl_o[c]),
            .pda     (pda_o[c]),
            .busy    (ch_busy[c]),
            .done    (ch_done[c])
        );
    end

    assign irq_o = int_st & int_en;
endmodule

// File: rtl/pg_dual_chk.sv
module pg_dual_chk
    import pg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [CTRL_W-1:0] ctrl,
    input logic [NCH-1:0]    int_st,
    input logic [NCH-1:0]    ch_busy,
    input logic [NCH-1:0]    ch_done,
    input logic [NCH-1:0]    pcl_o,
    input logic [NCH-1:0]    pda_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_a
        a_r6_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl[c] |-> (pcl_o[c] == ctrl[2*NCH + c] && pda_o[c] == ctrl[3*NCH + c]));
        a_r10_no_done_when_off: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl[c] |-> !ch_done[c]);
        a_r7_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            ch_done[c] |=> int_st[c]);
        a_r8_clear_only_by_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(int_st[c]) |-> $past(reg_we && reg_addr == ADDR_W'(A_INT_ST) && reg_wdata[c]));
        a_r5_data_steady_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_busy[c] && $past(ch_busy[c]) && !ctrl[NCH + c] && !$past(ctrl[NCH + c])
             && !$past(reg_we) && $rose(pcl_o[c])) |-> $stable(pda_o[c]));
    end
endmodule

bind pg_dual pg_dual_chk u_chk (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata,
    .ctrl, .int_st, .ch_busy, .ch_done, .pcl_o, .pda_o
);

// File: tb/sim_pg_dual.sv
module sim_pg_dual;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pcl_o, pda_o, irq_o;

    int checks = 0, fails = 0;
    bit finished = 0;

    int          bdiv[2], blen[2], breps[2];
    logic [63:0] bpat[2];
    logic [1:0]  bpol = '0, bic = '0, bid = '0, bien = '0;

    pg_dual u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input int a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 chk(req, reg_rdata, exp);
    endtask

    function automatic logic [31:0] ctrl_word(input logic [1:0] en);
        return {24'd0, bid, bic, bpol, en};
    endfunction

    task automatic cfg_ch(input int ch, input int dv, input logic [63:0] p, input int ln, input int rp);
        bdiv[ch] = dv; bpat[ch] = p; blen[ch] = ln; breps[ch] = rp;
        wr(1 + ch, dv);
        wr(3 + 2*ch, p[31:0]);
        wr(4 + 2*ch, p[63:32]);
        wr(7 + ch, (rp << 16) | ln);
    endtask

    function automatic int total(input int ch);
        int l;
        l = (blen[ch] > 63) ? 64 : blen[ch] + 1;
        return 2 * (bdiv[ch] + 1) * l * (breps[ch] + 1);
    endfunction

    function automatic logic [1:0] expv(input int ch, input logic run, input int t);
        int d, l, b, ph;
        d = bdiv[ch] + 1;
        l = (blen[ch] > 63) ? 64 : blen[ch] + 1;
        if (!run || t >= total(ch)) return {bic[ch], bid[ch]};
        b  = t / (2*d);
        ph = (t / d) % 2;
        return {ph[0] ^ bpol[ch], bpat[ch][b % l]};
    endfunction

    // Starts the channels in mask with one control write and checks every cycle
    task automatic run_seq(input logic [1:0] mask, input string req);
        int mx;
        mx = 0;
        for (int c = 0; c < 2; c++) if (mask[c] && total(c) > mx) mx = total(c);
        wr(0, ctrl_word(2'b00));
        wr(9, 32'h3);
        wr(0, ctrl_word(mask));
        @(posedge clk);
        for (int t = 0; t < mx + 3; t++) begin
            @(negedge clk);
            for (int c = 0; c < 2; c++) begin
                chk(req, {pcl_o[c], pda_o[c]}, expv(c, mask[c], t));
                chk({req, " R7 irq"}, irq_o[c], mask[c] && bien[c] && t >= total(c));
            end
            @(posedge clk);
        end
        rd("R7 done flags", 9, mask);
        rd("R6 enable kept", 0, ctrl_word(mask));
        wr(0, ctrl_word(2'b00));
    endtask

    task automatic t_reset();
        #1;
        chk("R6 reset pins", {pcl_o, pda_o}, 4'b0);
        chk("R7 reset irq", irq_o, 2'b0);
        for (int a = 0; a < 12; a++) rd("R1 reset value", a, 32'h0);
    endtask

    task automatic t_regs();
        wr(2, 32'hDEAD_BEEF);
        rd("R1 divider readback", 2, 32'hDEAD_BEEF);
        wr(8, 32'hFFFF_FFFF);
        rd("R1 shape readback", 8, 32'h003F_03FF);
        wr(10, 32'h3);
        bien = 2'b11;
        rd("R1 int enable readback", 10, 32'h3);
        rd("R1 unused address", 15, 32'h0);
    endtask

    task automatic t_basic();
        cfg_ch(0, 0, 64'h0000_0000_0000_00A5, 3, 1);
        run_seq(2'b01, "R2 R3 basic ch0");
    endtask

    task automatic t_pol();
        bpol = 2'b10; bic = 2'b11; bid = 2'b10;
        cfg_ch(1, 2, 64'hF0F0_0000_0000_0013, 4, 0);
        run_seq(2'b10, "R5 R6 polarity ch1");
        bpol = 2'b00; bic = 2'b00; bid = 2'b00;
    endtask

    task automatic t_sync();
        bpol = 2'b01;
        cfg_ch(0, 1, 64'h0123_4567_89AB_CDEF, 7, 2);
        cfg_ch(1, 0, 64'h0000_0000_0000_0006, 2, 3);
        run_seq(2'b11, "R9 sync start");
        bpol = 2'b00;
    endtask

    task automatic t_clamp();
        cfg_ch(0, 0, 64'h8000_0001_C3A5_5A3C, 100, 0);
        run_seq(2'b01, "R4 length clamp");
    endtask

    task automatic t_w1c();
        wr(9, 32'h3);
        cfg_ch(1, 0, 64'h1, 0, 0);
        wr(0, ctrl_word(2'b10));
        repeat (6) @(posedge clk);
        rd("R8 flag set", 9, 32'h2);
        wr(9, 32'h0);
        rd("R8 write zero keeps", 9, 32'h2);
        wr(9, 32'h1);
        rd("R8 other bit keeps", 9, 32'h2);
        wr(9, 32'h2);
        rd("R8 write one clears", 9, 32'h0);
        wr(0, ctrl_word(2'b00));
    endtask

    task automatic t_mask();
        wr(10, 32'h2);
        bien = 2'b10;
        cfg_ch(0, 0, 64'h5, 2, 0);
        run_seq(2'b01, "R7 masked irq");
        wr(10, 32'h3);
        bien = 2'b11;
        #1 chk("R7 irq after unmask", irq_o, 2'b01);
        wr(9, 32'h3);
    endtask

    task automatic t_abort();
        bic = 2'b01; bid = 2'b01;
        cfg_ch(0, 3, 64'hFFFF_0000_FFFF_0000, 63, 63);
        wr(0, ctrl_word(2'b00));
        wr(9, 32'h3);
        wr(0, ctrl_word(2'b01));
        repeat (50) @(posedge clk);
        wr(0, ctrl_word(2'b00));
        chk("R10 idle after abort", {pcl_o[0], pda_o[0]}, 2'b11);
        repeat (200) @(posedge clk);
        #1 chk("R10 idle later", {pcl_o[0], pda_o[0]}, 2'b11);
        chk("R10 no irq", irq_o, 2'b00);
        rd("R10 no done flag", 9, 32'h0);
        bic = 2'b00; bid = 2'b00;
        wr(0, ctrl_word(2'b00));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_basic();
        t_pol();
        t_sync();
        t_clamp();
        t_w1c();
        t_mask();
        t_abort();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule